// File: doc/BRIEF.md
# Radix Page-Table Walker

This block translates a 64-bit effective address into a real address. A request carries the address, the access type (fetch or data), the privilege state and the relocation enables. It also carries the current partition and process ID registers and the process-table base and size. The walker first checks for an untranslated access, which passes through unchanged. Otherwise it uses the top two address bits, together with the privilege state, to choose the partition and process IDs that apply.

For a translated access, the walker reads the process-table slot of the chosen process. That slot gives the root of a radix tree, the total span of the tree in address bits, and the entry count of the root level. The walker then steps down the tree, one 64-bit read per level, through a request/valid memory port. Each directory entry names its own next-level base and entry count, so the index field moves from level to level, and any level may end the walk with a leaf.

On completion the block gives a one-cycle done pulse. With it come either the real address, the page size, the leaf entry and the leaf's address, or a fault code. Only one walk runs at a time.

Top module: `radix_walker`

## Requirements
- R1: When `hv_mode` is high and relocation is off for the access type (`ir_en` for a fetch, `dr_en` for data), the walk is bypassed. `done` rises one cycle after `start`, `fault` is 0, and `res_real` is `ea` with bits 63:60 cleared. `res_psize`, `res_leaf`, `res_leaf_addr`, `res_lpid` and `res_pid` are 0, and no memory read is made.
- R2: With `hv_mode` high, `ea[63:62]` selects (`res_lpid`, `res_pid`) as follows: 0 → (0, `pid_reg`); 1 → (`lpid_reg`, `pid_reg`); 2 → (`lpid_reg`, 0); 3 → (0, 0).
- R3: With `hv_mode` low, quadrant 0 gives (`lpid_reg`, `pid_reg`) and quadrant 3 gives (`lpid_reg`, 0). Quadrants 1 and 2 end the request one cycle after `start` with `fault` = 1 (segment), and no memory read is made.
- R4: The process-table slot is read at `prt_base + pid*16`. If `pid*16 >= 2^(prt_size+12)`, the request ends one cycle after `start` with `fault` = 2 (no translation), and no memory read is made. In the slot, bits 55:12 give the root base (low 12 bits zero), bits 10:5 give the tree span in bits, and bits 4:0 give the root entry count exponent (nls).
- R5: For each level, with `rem` as the bits still untranslated and the effective address taken with bits 63:62 cleared: the index is `(ea >> (rem - nls))` masked to nls bits, and the entry is read at `base + index*8`. `rem` then drops by nls.
- R6: A level with nls below 5, or with nls above `rem`, ends the walk with `fault` = 3 (bad configuration).
- R7: An entry with bit 63 (valid) clear ends the walk with `fault` = 2.
- R8: A valid entry with bit 62 (leaf) set ends the walk with `fault` = 0. `res_real` takes entry bits 55:12 (as an address) above the new `rem`, and the effective address bits below it. `res_psize` is the new `rem`, `res_leaf` is the entry, and `res_leaf_addr` is the address it was read from.
- R9: A valid non-leaf entry gives the next-level base from bits 55:8 (low 8 bits zero) and the next nls from bits 4:0, and the walk continues.
- R10: At most `MAX_LEVELS` tree entries are read. A non-leaf entry at the last allowed level ends the walk with `fault` = 3.
- R11: `busy` is high from the cycle after an accepted `start` until the done cycle, in which it is low. A `start` raised while busy has no effect. `done` is a one-cycle pulse, and a `start` in the done cycle is accepted.
- R12: `mem_req` stays high with `mem_addr` unchanged until a cycle with `mem_rvalid` high, which delivers `mem_rdata` and ends that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a translation (taken when not busy) |
| ea | input | 64 | Effective address |
| is_fetch | input | 1 | Access is an instruction fetch |
| hv_mode | input | 1 | Hypervisor privilege state |
| ir_en | input | 1 | Relocation enable for fetches |
| dr_en | input | 1 | Relocation enable for data |
| lpid_reg | input | LPID_W | Current partition ID register |
| pid_reg | input | PID_W | Current process ID register |
| prt_base | input | 64 | Process-table base address |
| prt_size | input | 5 | Process-table size exponent (bytes = 2^(n+12)) |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 64 | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | 0 none, 1 segment, 2 no translation, 3 bad configuration |
| res_real | output | 64 | Real address |
| res_psize | output | 6 | Page size in address bits |
| res_leaf | output | 64 | Leaf entry |
| res_leaf_addr | output | 64 | Address of the leaf entry |
| res_lpid | output | LPID_W | Selected partition ID |
| res_pid | output | PID_W | Selected process ID |

## Verification
The finishing of one walk and the acceptance of the next can fall in the same cycle. While `done` is high the walker is already idle, so a `start` presented then is taken at once. The bench provokes this by raising the next `start` in every done cycle, through sweeps of hundreds of back-to-back requests. Untranslated and early-fault requests then finish in consecutive cycles. Each result is judged against the bench's own walk of its memory image, including the number of reads made, so a request dropped or merged at that boundary shows up as a wrong result or read count.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_SEGMENT = 2'd1,
        FLT_NOXLATE = 2'd2,
        FLT_BADCFG  = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRT  = 2'd1,
        ST_LVL  = 2'd2
    } walk_state_e;

    localparam int unsigned ENT_VALID_BIT = 63;
    localparam int unsigned ENT_LEAF_BIT  = 62;
    localparam logic [63:0] RPN_MASK      = 64'h00FF_FFFF_FFFF_F000;
    localparam logic [63:0] ROOT_MASK     = 64'h00FF_FFFF_FFFF_F000;
    localparam logic [63:0] NEXT_MASK     = 64'h00FF_FFFF_FFFF_FF00;
    localparam logic [63:0] REAL_MASK     = 64'h0FFF_FFFF_FFFF_FFFF;
    localparam int unsigned PRT_SLOT_SHIFT = 4;
    localparam int unsigned ENT_SHIFT      = 3;
    localparam int unsigned MIN_NLS        = 5;

endpackage

// File: rtl/rw_id_select.sv
module rw_id_select #(
    parameter int unsigned LPID_W = 12,
    parameter int unsigned PID_W  = 20
) (
    input  logic              hv,
    input  logic [1:0]        quad,
    input  logic [LPID_W-1:0] lpid_reg,
    input  logic [PID_W-1:0]  pid_reg,
    output logic [LPID_W-1:0] lpid,
    output logic [PID_W-1:0]  pid,
    output logic              illegal
);

    always_comb begin
        lpid    = '0;
        pid     = '0;
        illegal = 1'b0;
        if (hv) begin
            unique case (quad)
                2'd0: pid = pid_reg;
                2'd1: begin lpid = lpid_reg; pid = pid_reg; end
                2'd2: lpid = lpid_reg;
                default: ;
            endcase
        end else begin
            unique case (quad)
                2'd0: begin lpid = lpid_reg; pid = pid_reg; end
                2'd3: lpid = lpid_reg;
                default: illegal = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/rw_level_index.sv
module rw_level_index
    import radix_walk_pkg::*;
(
    input  logic [63:0] ea_eff,
    input  logic [63:0] base,
    input  logic [4:0]  nls,
    input  logic [5:0]  rem,
    output logic        bad,
    output logic [63:0] entry_addr
);

    logic [5:0]  shamt;
    logic [63:0] idx_mask;
    logic [63:0] idx;

    always_comb begin
        bad        = (nls < 5'(MIN_NLS)) || ({1'b0, nls} > rem);
        shamt      = rem - {1'b0, nls};
        idx_mask   = (64'd1 << nls) - 64'd1;
        idx        = (ea_eff >> shamt) & idx_mask;
        entry_addr = base + (idx << ENT_SHIFT);
    end

endmodule

// File: rtl/rw_leaf_join.sv
module rw_leaf_join
    import radix_walk_pkg::*;
(
    input  logic [63:0] entry,
    input  logic [63:0] ea_eff,
    input  logic [5:0]  rem,
    output logic [63:0] real_addr
);

    logic [63:0] low_mask;

    always_comb begin
        low_mask  = (64'd1 << rem) - 64'd1;
        real_addr = (entry & RPN_MASK & ~low_mask) | (ea_eff & low_mask);
    end

endmodule

// File: rtl/radix_walker.sv
module radix_walker
    import radix_walk_pkg::*;
#(
    parameter int unsigned LPID_W     = 12,
    parameter int unsigned PID_W      = 20,
    parameter int unsigned MAX_LEVELS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [63:0]       ea,
    input  logic              is_fetch,
    input  logic              hv_mode,
    input  logic              ir_en,
    input  logic              dr_en,
    input  logic [LPID_W-1:0] lpid_reg,
    input  logic [PID_W-1:0]  pid_reg,
    input  logic [63:0]       prt_base,
    input  logic [4:0]        prt_size,
    output logic              busy,
    output logic              mem_req,
    output logic [63:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    output logic              done,
    output logic [1:0]        fault,
    output logic [63:0]       res_real,
    output logic [5:0]        res_psize,
    output logic [63:0]       res_leaf,
    output logic [63:0]       res_leaf_addr,
    output logic [LPID_W-1:0] res_lpid,
    output logic [PID_W-1:0]  res_pid
);

    localparam int unsigned LVL_W = $clog2(MAX_LEVELS + 1);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(MAX_LEVELS - 1);

    typedef struct packed {
        walk_state_e       state;
        logic [61:0]       ea_lo;
        logic [4:0]        nls;
        logic [5:0]        rem;
        logic [LVL_W-1:0]  level;
        logic              mem_req;
        logic [63:0]       mem_addr;
        logic              done;
        fault_e            fault;
        logic [63:0]       ra;
        logic [5:0]        psize;
        logic [63:0]       leaf;
        logic [63:0]       leaf_addr;
        logic [LPID_W-1:0] lpid;
        logic [PID_W-1:0]  pid;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic [LPID_W-1:0] sel_lpid;
    logic [PID_W-1:0]  sel_pid;
    logic              sel_illegal;
    logic              is_real;
    logic              pid_fits;
    logic [63:0]       ea_eff_q;
    logic [5:0]        rem_after;
    logic [63:0]       lc_base;
    logic [4:0]        lc_nls;
    logic [5:0]        lc_rem;
    logic              lc_bad;
    logic [63:0]       lc_addr;
    logic [63:0]       leaf_ra;

    rw_id_select #(.LPID_W(LPID_W), .PID_W(PID_W)) u_idsel (
        .hv       (hv_mode),
        .quad     (ea[63:62]),
        .lpid_reg (lpid_reg),
        .pid_reg  (pid_reg),
        .lpid     (sel_lpid),
        .pid      (sel_pid),
        .illegal  (sel_illegal)
    );

    rw_level_index u_lvl (
        .ea_eff     (ea_eff_q),
        .base       (lc_base),
        .nls        (lc_nls),
        .rem        (lc_rem),
        .bad        (lc_bad),
        .entry_addr (lc_addr)
    );

    rw_leaf_join u_leaf (
        .entry     (mem_rdata),
        .ea_eff    (ea_eff_q),
        .rem       (rem_after),
        .real_addr (leaf_ra)
    );

    always_comb begin
        ea_eff_q  = {2'b00, r_q.ea_lo};
        rem_after = r_q.rem - {1'b0, r_q.nls};
        is_real   = hv_mode && (is_fetch ? !ir_en : !dr_en);
        pid_fits  = ((64'(sel_pid)) >> ({1'b0, prt_size} + 6'd8)) == 64'd0;
        lc_nls    = mem_rdata[4:0];
        if (r_q.state == ST_PRT) begin
            lc_base = mem_rdata & ROOT_MASK;
            lc_rem  = mem_rdata[10:5];
        end else begin
            lc_base = mem_rdata & NEXT_MASK;
            lc_rem  = rem_after;
        end
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.ea_lo     = ea[61:0];
                    r_d.ra        = '0;
                    r_d.psize     = '0;
                    r_d.leaf      = '0;
                    r_d.leaf_addr = '0;
                    r_d.lpid      = sel_lpid;
                    r_d.pid       = sel_pid;
                    r_d.fault     = FLT_NONE;
                    r_d.level     = '0;
                    if (is_real) begin
                        r_d.done = 1'b1;
                        r_d.ra   = ea & REAL_MASK;
                        r_d.lpid = '0;
                        r_d.pid  = '0;
                    end else if (sel_illegal) begin
                        r_d.done  = 1'b1;
                        r_d.fault = FLT_SEGMENT;
                    end else if (!pid_fits) begin
                        r_d.done  = 1'b1;
                        r_d.fault = FLT_NOXLATE;
                    end else begin
                        r_d.state    = ST_PRT;
                        r_d.mem_req  = 1'b1;
                        r_d.mem_addr = prt_base + (64'(sel_pid) << PRT_SLOT_SHIFT);
                    end
                end
            end
            ST_PRT: begin
                if (mem_rvalid) begin
                    r_d.mem_req = 1'b0;
                    if (lc_bad) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.fault = FLT_BADCFG;
                    end else begin
                        r_d.state    = ST_LVL;
                        r_d.nls      = lc_nls;
                        r_d.rem      = lc_rem;
                        r_d.mem_addr = lc_addr;
                        r_d.mem_req  = 1'b1;
                    end
                end
            end
            ST_LVL: begin
                if (mem_rvalid) begin
                    r_d.mem_req = 1'b0;
                    if (!mem_rdata[ENT_VALID_BIT]) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.fault = FLT_NOXLATE;
                    end else if (mem_rdata[ENT_LEAF_BIT]) begin
                        r_d.state     = ST_IDLE;
                        r_d.done      = 1'b1;
                        r_d.ra        = leaf_ra;
                        r_d.psize     = rem_after;
                        r_d.leaf      = mem_rdata;
                        r_d.leaf_addr = r_q.mem_addr;
                    end else if (r_q.level == LAST_LVL || lc_bad) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.fault = FLT_BADCFG;
                    end else begin
                        r_d.level    = r_q.level + LVL_W'(1);
                        r_d.nls      = lc_nls;
                        r_d.rem      = rem_after;
                        r_d.mem_addr = lc_addr;
                        r_d.mem_req  = 1'b1;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy          = (r_q.state != ST_IDLE);
    assign mem_req       = r_q.mem_req;
    assign mem_addr      = r_q.mem_addr;
    assign done          = r_q.done;
    assign fault         = r_q.fault;
    assign res_real      = r_q.ra;
    assign res_psize     = r_q.psize;
    assign res_leaf      = r_q.leaf;
    assign res_leaf_addr = r_q.leaf_addr;
    assign res_lpid      = r_q.lpid;
    assign res_pid       = r_q.pid;

    assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)))
        else $error("read request dropped or moved before data");

    assert_idle_no_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req)
        else $error("memory request while idle");

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy)
        else $error("done while still busy");

    assert_seg_no_walk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault == FLT_SEGMENT) |-> $past(!busy))
        else $error("segment fault after a walk started");

    assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.level < LVL_W'(MAX_LEVELS))
        else $error("level count beyond limit");

endmodule

// File: tb/radix_walker_tb.sv
module radix_walker_tb;

    localparam int LPID_W = 12;
    localparam int PID_W  = 20;
    localparam int MAXL   = 4;
    localparam logic [63:0] V = 64'h8000_0000_0000_0000;
    localparam logic [63:0] L = 64'h4000_0000_0000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [63:0] ea = '0;
    logic is_fetch = 1'b0, hv_mode = 1'b0, ir_en = 1'b1, dr_en = 1'b1;
    logic [LPID_W-1:0] lpid_reg = 12'd5;
    logic [PID_W-1:0]  pid_reg = '0;
    logic [63:0] prt_base = '0;
    logic [4:0]  prt_size = '0;
    logic busy, mem_req, done;
    logic [63:0] mem_addr;
    logic mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic [1:0] fault;
    logic [63:0] res_real, res_leaf, res_leaf_addr;
    logic [5:0] res_psize;
    logic [LPID_W-1:0] res_lpid;
    logic [PID_W-1:0] res_pid;

    int checks = 0, failures = 0, rd_cnt = 0, lat = 0, lat_cnt = 0, walks = 0;
    int hold_viol = 0;
    logic [63:0] mem [0:2047];

    always #10 clk = ~clk;

    radix_walker #(.LPID_W(LPID_W), .PID_W(PID_W), .MAX_LEVELS(MAXL)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .is_fetch(is_fetch),
        .hv_mode(hv_mode), .ir_en(ir_en), .dr_en(dr_en), .lpid_reg(lpid_reg),
        .pid_reg(pid_reg), .prt_base(prt_base), .prt_size(prt_size), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .fault(fault), .res_real(res_real),
        .res_psize(res_psize), .res_leaf(res_leaf), .res_leaf_addr(res_leaf_addr),
        .res_lpid(res_lpid), .res_pid(res_pid)
    );

    function automatic logic [63:0] rd(input logic [63:0] a);
        if (a < 64'd16384) return mem[a[13:3]];
        return 64'd0;
    endfunction

    // memory model with a latency that varies per walk
    always @(posedge clk) begin
        if (mem_rvalid) mem_rvalid <= 1'b0;
        else if (mem_req) begin
            if (lat_cnt >= lat) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= rd(mem_addr);
                lat_cnt    <= 0;
                rd_cnt     <= rd_cnt + 1;
            end else lat_cnt <= lat_cnt + 1;
        end
    end

    // request hold monitor (R12)
    logic p_req = 1'b0, p_rv = 1'b0;
    logic [63:0] p_addr = '0;
    always @(negedge clk) begin
        if (rst_n && p_req && !p_rv && !(mem_req && mem_addr == p_addr)) hold_viol <= hold_viol + 1;
        p_req  <= mem_req;
        p_rv   <= mem_rvalid;
        p_addr <= mem_addr;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected results
    logic [1:0]  x_fault;
    logic [63:0] x_ra, x_leaf, x_laddr;
    logic [5:0]  x_ps;
    logic [LPID_W-1:0] x_lpid;
    logic [PID_W-1:0]  x_pid;
    int x_reads;
    string x_tag, x_idtag;

    task automatic model(input logic [63:0] e, input logic f, input logic h,
                         input logic ir, input logic dr, input logic [PID_W-1:0] pr,
                         input logic [4:0] ps);
        logic [63:0] eae, ent, base, a, idx, m;
        logic [5:0] rem;
        logic [4:0] nls;
        logic fin;
        x_fault = 2'd0; x_ra = '0; x_leaf = '0; x_laddr = '0; x_ps = '0;
        x_lpid = '0; x_pid = '0; x_reads = 0;
        x_idtag = h ? "R2" : "R3";
        if (h && (f ? !ir : !dr)) begin
            x_tag = "R1"; x_ra = e & 64'h0FFF_FFFF_FFFF_FFFF; return;
        end
        case ({h, e[63:62]})
            3'b100: x_pid = pr;
            3'b101: begin x_lpid = lpid_reg; x_pid = pr; end
            3'b110: x_lpid = lpid_reg;
            3'b111: ;
            3'b000: begin x_lpid = lpid_reg; x_pid = pr; end
            3'b011: x_lpid = lpid_reg;
            default: begin x_tag = "R3"; x_fault = 2'd1; return; end
        endcase
        if ((64'(x_pid) >> (int'(ps) + 8)) != 0) begin
            x_tag = "R4"; x_fault = 2'd2; return;
        end
        ent = rd(prt_base + 64'(x_pid) * 16); x_reads = 1;
        base = ent & 64'h00FF_FFFF_FFFF_F000; nls = ent[4:0]; rem = ent[10:5];
        eae = {2'b00, e[61:0]};
        fin = 1'b0;
        for (int lv = 0; lv < MAXL && !fin; lv++) begin
            if (nls < 5 || {1'b0, nls} > rem) begin
                x_tag = "R6"; x_fault = 2'd3; fin = 1'b1;
            end else begin
                idx = (eae >> (rem - {1'b0, nls})) & ((64'd1 << nls) - 1);
                a = base + idx * 8;
                ent = rd(a); x_reads++;
                rem = rem - {1'b0, nls};
                if (!ent[63]) begin
                    x_tag = "R7"; x_fault = 2'd2; fin = 1'b1;
                end else if (ent[62]) begin
                    m = (64'd1 << rem) - 1;
                    x_ra = (ent & 64'h00FF_FFFF_FFFF_F000 & ~m) | (eae & m);
                    x_ps = rem; x_leaf = ent; x_laddr = a;
                    x_tag = (lv > 0) ? "R9" : "R8"; fin = 1'b1;
                end else if (lv == MAXL - 1) begin
                    x_tag = "R10"; x_fault = 2'd3; fin = 1'b1;
                end else begin
                    base = ent & 64'h00FF_FFFF_FFFF_FF00; nls = ent[4:0];
                end
            end
        end
    endtask

    task automatic wait_done(output bit ok);
        int n = 0;
        while (!done && n < 400) begin @(negedge clk); n++; end
        ok = done;
    endtask

    task automatic walk(input logic [63:0] e, input logic f, input logic h,
                        input logic ir, input logic dr, input logic [PID_W-1:0] pr,
                        input logic [4:0] ps);
        int rd0;
        bit ok;
        model(e, f, h, ir, dr, pr, ps);
        ea = e; is_fetch = f; hv_mode = h; ir_en = ir; dr_en = dr; pid_reg = pr; prt_size = ps;
        lat = walks % 3; walks++;
        rd0 = rd_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        chk(ok, "R11 done seen", 64'(ok), 64'd1);
        if (!ok) return;
        chk(!busy, "R11 busy low at done", 64'(busy), 64'd0);
        chk(fault == x_fault, x_tag, 64'(fault), 64'(x_fault));
        chk(rd_cnt - rd0 == x_reads, "R5 read count", 64'(rd_cnt - rd0), 64'(x_reads));
        if (x_fault == 2'd0) begin
            chk(res_real == x_ra, x_tag, res_real, x_ra);
            chk(res_psize == x_ps, "R8 page size", 64'(res_psize), 64'(x_ps));
            chk(res_leaf == x_leaf, "R8 leaf entry", res_leaf, x_leaf);
            chk(res_leaf_addr == x_laddr, "R5 leaf address", res_leaf_addr, x_laddr);
            chk(res_lpid == x_lpid, x_tag == "R1" ? "R1" : x_idtag, 64'(res_lpid), 64'(x_lpid));
            chk(res_pid == x_pid, x_tag == "R1" ? "R1" : x_idtag, 64'(res_pid), 64'(x_pid));
        end
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                failures++; checks++;
                $display("FAIL watchdog actual=%0d expected<150000", wd);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        logic [PID_W-1:0] pids [0:5];
        bit ok;
        logic [63:0] ea_a;
        pids[0] = 0; pids[1] = 1; pids[2] = 2; pids[3] = 3; pids[4] = 4; pids[5] = 300;
        for (int i = 0; i < 2048; i++) mem[i] = '0;
        mem[0] = 64'h1000 | (64'd24 << 5) | 64'd6;
        mem[2] = 64'h1000 | (64'd24 << 5) | 64'd4;
        mem[4] = 64'h1000 | (64'd20 << 5) | 64'd6;
        mem[6] = 64'h3000 | (64'd60 << 5) | 64'd5;
        mem[8] = 64'h1000 | (64'd10 << 5) | 64'd6;
        for (int i = 0; i < 64; i++)
            case (i % 4)
                0: mem[512 + i] = V | L | ((64'(i) * 64'h123 + 64'h40) << 12);
                1: mem[512 + i] = '0;
                2: mem[512 + i] = V | 64'h2000 | 64'd6;
                default: mem[512 + i] = V | 64'h2000 | 64'd3;
            endcase
        for (int j = 0; j < 64; j++)
            case (j % 3)
                0: mem[1024 + j] = V | L | (64'(j) << 20) | 64'hABC000;
                1: mem[1024 + j] = '0;
                default: mem[1024 + j] = V | 64'h2800 | 64'd8;
            endcase
        for (int k = 0; k < 256; k++) mem[1280 + k] = V | L | (64'(k) << 16) | 64'h5000;
        for (int k = 0; k < 32; k++) mem[1536 + k] = V | 64'h3000 | 64'd5;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req, "R11 reset state", {61'd0, busy, done, mem_req}, 64'd0);

        // untranslated accesses
        for (int c = 0; c < 16; c++) begin
            ea_a = {4'(c), 60'h123_4567_89AB_CDE} ^ (64'(c) << 33);
            walk(ea_a, c[0], c[1], c[2], c[3], 20'd1, 5'd0);
        end

        // main sweep: privilege x quadrant x pid x address pattern
        for (int h = 0; h < 2; h++)
            for (int q = 0; q < 4; q++)
                for (int p = 0; p < 6; p++)
                    for (int k = 0; k < 16; k++) begin
                        ea_a = (64'(k) * 64'h9E37_79B9_7F4A_7C15) ^ (64'(k) << 18);
                        ea_a[63:62] = 2'(q);
                        walk(ea_a, k[0], h[0], 1'b1, 1'b1, pids[p], 5'd0);
                    end

        // larger process table lets pid 300 in (R4)
        walk(64'h0000_0000_0012_3456, 1'b0, 1'b1, 1'b1, 1'b1, 20'd300, 5'd1);

        // R11: start while busy is ignored
        model(64'h0000_0000_0088_1234, 1'b0, 1'b1, 1'b1, 1'b1, 20'd0, 5'd0);
        ea = 64'h0000_0000_0088_1234; hv_mode = 1'b1; ir_en = 1'b1; dr_en = 1'b1;
        pid_reg = 20'd0; prt_size = 5'd0; lat = 2;
        start = 1'b1; @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk(busy, "R11 busy during walk", 64'(busy), 64'd1);
        ea = 64'h0000_0000_0000_0000; start = 1'b1; @(negedge clk); start = 1'b0;
        ea = 64'h0000_0000_0088_1234;
        wait_done(ok);
        chk(ok && res_real == x_ra, "R11 ignored start", res_real, x_ra);
        @(negedge clk);
        chk(!done && !busy, "R11 no second walk", {62'd0, done, busy}, 64'd0);

        chk(hold_viol == 0, "R12 request hold", 64'(hold_viol), 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule